// File: doc/BRIEF.md
# Cross-Coupled Reference Rate Prescaler

This block turns one fast master reference into a family of slower reference rates. It uses a chain of small counter stages wired as a mixed-radix cascade. A divide-by-2 stage runs off the master clock. A combined /2 and /5 section runs off that stage. The /5 output then feeds back into a /2-/4 section. Each derived rate is a single-cycle enable strobe in the master clock domain, so nothing downstream is clocked by a ripple-derived clock.

A 3-bit range code and a range bit pick one strobe to drive a downstream decade chain. The range bit chooses between a fast (x1) path and a slow (x10) path. One code value stands for the external / acquisition-stop source. In that case the internal reference is halted: every stage keeps its count and every strobe stays low. When the code changes away, counting resumes from the same phase.

Top module: `refPrescaler`

## Requirements
- R1: While `rst` is high, every output is low. After `rst` falls, all stage counts start from zero, so the first `tapStb[0]` pulse appears in the second running cycle.
- R2: `tapStb[0]` (master/2) pulses for one cycle in every 2 running cycles, on running cycles n where n mod 2 = 1 (n counts running cycles from 0 after reset).
- R3: `tapStb[1]` (master/4) pulses when n mod 4 = 3, always together with `tapStb[0]`.
- R4: `tapStb[2]` (master/10) pulses when n mod 10 = 9, which is the last state (count 4) of the /5 stage.
- R5: `tapStb[3]` (master/20, the /2 tap of the /2-/4 section) pulses when n mod 20 = 19.
- R6: `tapStb[4]` (master/40, the /4 tap of the /2-/4 section) pulses when n mod 40 = 39, always together with `tapStb[3]`.
- R7: With `rangeX10` = 0 and `rangeCode` 0 to 4, `pickStb` equals `tapStb[rangeCode]` in the same cycle.
- R8: With `rangeX10` = 1, code 0 routes `tapStb[3]` and code 1 routes `tapStb[4]` to `pickStb`.
- R9: Unused codes hold `pickStb` low. These are codes 5 and 6 with `rangeX10` = 0, and codes 2 to 6 with `rangeX10` = 1.
- R10: With `rangeCode` = 7 (external/stop, for either range bit), all strobes and `pickStb` are low and no counter advances. When the code leaves 7, the count n continues from its held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rangeCode | input | 3 | Tap select; 7 selects external/stop |
| rangeX10 | input | 1 | 0 = x1 path, 1 = x10 path |
| tapStb | output | 5 | Per-rate enable strobes, index 0 = /2 up to index 4 = /40 |
| pickStb | output | 1 | Strobe routed to the decade chain |

## Verification
The assertions assume that `rangeCode` and `rangeX10` are static with respect to the clock edge. They also assume a stop request lasts at least one full cycle, so that "hold" can be judged between two consecutive edges. The stimulus changes selects and reset only at the falling clock edge and keeps each setting for many cycles. It covers every code under both range bits, a stop entered mid-phase, and a reset asserted in the middle of a run.

// File: rtl/refPrescalerPkg.sv
package refPrescalerPkg;
  localparam int NUM_TAPS = 5;
  localparam int CODE_W   = 3;

  typedef struct packed {
    logic                haltRef;
    logic [NUM_TAPS-1:0] pickHot;
  } ctlStrobes_t;
endpackage

// File: rtl/prescaleCtrl.sv
module prescaleCtrl
  import refPrescalerPkg::*;
#(
  parameter int STOP_CODE = 7,
  parameter int X10_BASE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rangeCode,
  input  logic              rangeX10,
  output ctlStrobes_t       ctl
);
  localparam int X10_SPAN = NUM_TAPS - X10_BASE;

  always_comb begin
    ctl = '0;
    if (int'(rangeCode) == STOP_CODE) begin
      ctl.haltRef = 1'b1;
    end else if (!rangeX10) begin
      for (int i = 0; i < NUM_TAPS; i++)
        if (int'(rangeCode) == i) ctl.pickHot[i] = 1'b1;
    end else begin
      for (int i = 0; i < X10_SPAN; i++)
        if (int'(rangeCode) == i) ctl.pickHot[X10_BASE+i] = 1'b1;
    end
  end

  p_single_pick_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.pickHot));
  p_halt_no_pick_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.haltRef |-> (ctl.pickHot == '0));
endmodule

// File: rtl/prescaleDatapath.sv
module prescaleDatapath
  import refPrescalerPkg::*;
#(
  parameter int DIV_FIRST = 2,
  parameter int DIV_MID_A = 2,
  parameter int DIV_MID_B = 5,
  parameter int DIV_LAST  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         ctl,
  output logic [NUM_TAPS-1:0] tapStb,
  output logic                pickStb
);
  localparam int W_FIRST = $clog2(DIV_FIRST);
  localparam int W_MID_A = $clog2(DIV_MID_A);
  localparam int W_MID_B = $clog2(DIV_MID_B);
  localparam int W_LAST  = $clog2(DIV_LAST);
  localparam int LAST_HALF = DIV_LAST / 2;

  logic [W_FIRST-1:0] cntFirst;
  logic [W_MID_A-1:0] cntMidA;
  logic [W_MID_B-1:0] cntMidB;
  logic [W_LAST-1:0]  cntLast;
  logic run, enFirst, enMidA, enMidB, enLastHalf, enLastFull;

  assign run        = !rst && !ctl.haltRef;
  assign enFirst    = run && (int'(cntFirst) == DIV_FIRST - 1);
  assign enMidA     = enFirst && (int'(cntMidA) == DIV_MID_A - 1);
  assign enMidB     = enFirst && (int'(cntMidB) == DIV_MID_B - 1);
  assign enLastHalf = enMidB && (int'(cntLast) % LAST_HALF == LAST_HALF - 1);
  assign enLastFull = enMidB && (int'(cntLast) == DIV_LAST - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntFirst <= '0;
      cntMidA  <= '0;
      cntMidB  <= '0;
      cntLast  <= '0;
    end else if (run) begin
      cntFirst <= enFirst ? '0 : cntFirst + 1'b1;
      if (enFirst) begin
        cntMidA <= enMidA ? '0 : cntMidA + 1'b1;
        cntMidB <= enMidB ? '0 : cntMidB + 1'b1;
      end
      if (enMidB)
        cntLast <= enLastFull ? '0 : cntLast + 1'b1;
    end
  end

  assign tapStb  = {enLastFull, enLastHalf, enMidB, enMidA, enFirst};
  assign pickStb = |(tapStb & ctl.pickHot);

  p_mid_on_first_r3: assert property (@(posedge clk) disable iff (rst)
    tapStb[1] |-> tapStb[0]);
  p_mid_b_range_r4: assert property (@(posedge clk) disable iff (rst)
    int'(cntMidB) < DIV_MID_B);
  p_tap2_single_r4: assert property (@(posedge clk) disable iff (rst)
    tapStb[2] |=> !tapStb[2]);
  p_full_on_half_r6: assert property (@(posedge clk) disable iff (rst)
    tapStb[4] |-> tapStb[3]);
  p_hold_when_halted_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.haltRef |=> ($stable(cntFirst) && $stable(cntMidB) && $stable(cntLast)));
  p_quiet_when_halted_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.haltRef |-> (tapStb == '0 && !pickStb));
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    rst |-> (tapStb == '0 && !pickStb));
endmodule

// File: rtl/refPrescaler.sv
module refPrescaler
  import refPrescalerPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   rangeCode,
  input  logic                rangeX10,
  output logic [NUM_TAPS-1:0] tapStb,
  output logic                pickStb
);
  ctlStrobes_t ctl;

  prescaleCtrl u_ctrl (
    .clk(clk), .rst(rst), .rangeCode(rangeCode), .rangeX10(rangeX10), .ctl(ctl)
  );

  prescaleDatapath u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .tapStb(tapStb), .pickStb(pickStb)
  );

  p_unused_low_r9: assert property (@(posedge clk) disable iff (rst)
    ((!rangeX10 && (rangeCode == 3'd5 || rangeCode == 3'd6)) ||
     (rangeX10 && rangeCode >= 3'd2 && rangeCode <= 3'd6)) |-> !pickStb);
  p_x10_route_r8: assert property (@(posedge clk) disable iff (rst)
    (rangeX10 && rangeCode == 3'd1) |-> (pickStb == tapStb[4]));
endmodule

// File: tb/sim_refPrescaler.sv
module sim_refPrescaler;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rangeCode = 3'd0;
  logic rangeX10 = 1'b0;
  logic [4:0] tapStb;
  logic pickStb;

  int vectors = 0;
  int miscompares = 0;
  int n = 0;
  bit done = 1'b0;

  refPrescaler u0 (
    .clk(clk), .rst(rst), .rangeCode(rangeCode), .rangeX10(rangeX10),
    .tapStb(tapStb), .pickStb(pickStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] modelTaps(int cnt);
    int period[5] = '{2, 4, 10, 20, 40};
    logic [4:0] t;
    for (int i = 0; i < 5; i++) t[i] = (cnt % period[i]) == period[i] - 1;
    return t;
  endfunction

  always @(posedge clk) begin
    if (rst) n <= 0;
    else if (rangeCode != 3'd7) n <= n + 1;
  end

  always @(negedge clk) begin
    logic [4:0] expTaps;
    logic expPick;
    string reqTag;
    if (!done) begin
      expTaps = (rst || rangeCode == 3'd7) ? 5'd0 : modelTaps(n);
      expPick = 1'b0;
      if (!rst && rangeCode != 3'd7) begin
        if (!rangeX10 && rangeCode <= 3'd4) expPick = expTaps[rangeCode];
        else if (rangeX10 && rangeCode == 3'd0) expPick = expTaps[3];
        else if (rangeX10 && rangeCode == 3'd1) expPick = expTaps[4];
      end
      vectors++;
      if (tapStb !== expTaps) begin
        miscompares++;
        if (rst) reqTag = "R1";
        else if (rangeCode == 3'd7) reqTag = "R10";
        else if (tapStb[0] !== expTaps[0]) reqTag = "R2";
        else if (tapStb[1] !== expTaps[1]) reqTag = "R3";
        else if (tapStb[2] !== expTaps[2]) reqTag = "R4";
        else if (tapStb[3] !== expTaps[3]) reqTag = "R5";
        else reqTag = "R6";
        $display("FAIL %s tapStb n=%0d actual=%b expected=%b", reqTag, n, tapStb, expTaps);
      end
      vectors++;
      if (pickStb !== expPick) begin
        miscompares++;
        if (rst) reqTag = "R1";
        else if (rangeCode == 3'd7) reqTag = "R10";
        else if (!rangeX10 && rangeCode <= 3'd4) reqTag = "R7";
        else if (rangeX10 && rangeCode <= 3'd1) reqTag = "R8";
        else reqTag = "R9";
        $display("FAIL %s pickStb code=%0d x10=%b actual=%b expected=%b",
                 reqTag, rangeCode, rangeX10, pickStb, expPick);
      end
    end
  end

  task automatic runFor(int cycles, logic [2:0] code, logic x10);
    @(negedge clk);
    rangeCode = code;
    rangeX10 = x10;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2..R6 and R7: walk every x1 code
    for (int c = 0; c <= 4; c++) runFor(90, 3'(c), 1'b0);
    // R9: unused x1 codes
    runFor(45, 3'd5, 1'b0);
    runFor(45, 3'd6, 1'b0);
    // R10: stop mid-phase, then resume
    runFor(7, 3'd4, 1'b0);
    runFor(30, 3'd7, 1'b0);
    runFor(90, 3'd3, 1'b0);
    // R8 and R9: x10 path
    for (int c = 0; c <= 6; c++) runFor(85, 3'(c), 1'b1);
    runFor(13, 3'd7, 1'b1);
    runFor(60, 3'd1, 1'b1);
    // R1: reset asserted mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    runFor(120, 3'd2, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule